// File: doc/BRIEF.md
# LPC Memory Read Target

This block is the peripheral end of a memory read transaction on the Low Pin Count bus. Each clock it samples a 4-bit multiplexed nibble bus and an active-low framing strobe. It recognises a start nibble, checks the cycle-type nibble, and assembles a 32-bit address from eight nibbles that arrive most significant first. It then waits out the host's two-clock turnaround and takes over the bus. It answers with a ready sync nibble and one data byte, sent low nibble first, and hands the bus back through its own two-clock turnaround.

The byte comes from a simple synchronous read port. The block raises a one-clock read strobe with the address, and the backend returns the byte on the following clock. Bus ownership is visible as a drive value plus a separate output enable, which the chip-level pad ring turns into a tri-state buffer.

Top module: `lpc_rd_target`

## Requirements
- R1: While reset is asserted, and in the first clock after it is released, `nib_oe` and `mem_rd` are 0. Reset asserted in the middle of the response clears `nib_oe` at once.
- R2: A transaction starts only when `frm_n` is 0 and `nib_in` is 4'b0000 at the same clock edge. Any other nibble seen with `frm_n` low leaves the block idle, and the block never drives the bus.
- R3: The clock after the start carries the cycle type. The block responds only when bits 3:2 are 01 and bit 1 is 0; bit 0 is a don't-care. Any other type returns the block to idle with `nib_oe` held at 0.
- R4: The eight clocks after the cycle type carry the address, bits 31:28 first and bits 3:0 last. `mem_rd` is high for exactly one clock, the clock after the last address nibble (clock 11 when the start is clock 1). In that clock `mem_addr` equals the full address.
- R5: `nib_oe` stays 0 through both host turnaround clocks (clocks 11 and 12). It is 1 from clock 13 through clock 16 only, and it first rises two clocks after `mem_rd`.
- R6: In clock 13 the block drives the sync nibble 4'b0000.
- R7: `mem_data` is captured in the clock after `mem_rd` (clock 12). Bits 3:0 of that byte are driven in clock 14 and bits 7:4 in clock 15. Later changes of `mem_data` have no effect on the byte.
- R8: In clock 16 the block drives 4'b1111. In clock 17 `nib_oe` is 0 and the bus belongs to the host again.
- R9: A start (`frm_n` 0 with 4'b0000) seen at any point inside a transaction abandons it and begins decoding a new cycle type on the next clock.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| frm_n | input | 1 | Active-low framing strobe from the host |
| nib_in | input | 4 | Nibble bus value as sampled |
| nib_out | output | 4 | Nibble the target drives |
| nib_oe | output | 1 | Output enable for `nib_out` |
| mem_rd | output | 1 | One-clock backend read strobe |
| mem_addr | output | 32 | Backend read address |
| mem_data | input | 8 | Backend byte, valid the clock after `mem_rd` |

## Verification
The hardest cases to reach are an interrupted transaction: a fresh start arriving in the middle of the address, and a reset landing while the target owns the bus. The bench drives a partial cycle by hand, then either injects a new start or pulls reset at the point where the enable is high. It then confirms that the enable drops and that a following full read is answered correctly. The backend model also zeroes its byte one clock after each read, so a target that samples late returns wrong data.

// File: rtl/lpc_rd_pkg.sv
package lpc_rd_pkg;

   typedef enum logic [3:0] {
      ST_IDLE,
      ST_CTYPE,
      ST_ADDR,
      ST_HTA0,
      ST_HTA1,
      ST_SYNC,
      ST_DLO,
      ST_DHI,
      ST_REL
   } lpc_st_e;

   localparam logic [3:0] NIB_START = 4'b0000;
   localparam logic [3:0] NIB_READY = 4'b0000;
   localparam logic [3:0] NIB_ONES  = 4'b1111;

   // memory cycle: bits 3:2 = 01, read: bit 1 = 0, bit 0 don't-care
   function automatic logic is_mem_read(input logic [3:0] t);
      return (t[3:1] == 3'b010);
   endfunction

endpackage

// File: rtl/lpc_rd_addr_cap.sv
module lpc_rd_addr_cap #(
   parameter int ADDR_W   = 32,
   parameter bit SHIFT_IN = 1'b1,
   localparam int NIBS    = ADDR_W / 4,
   localparam int IDX_W   = $clog2(NIBS)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load,
   input  logic [IDX_W-1:0]  idx,
   input  logic [3:0]        nib,
   output logic [ADDR_W-1:0] addr
);

   logic [ADDR_W-1:0] addr_q;

   generate
      if (SHIFT_IN) begin : g_shift
         logic unused_idx;
         assign unused_idx = ^idx;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)    addr_q <= '0;
            else if (load) addr_q <= {addr_q[ADDR_W-5:0], nib};
         end
      end else begin : g_index
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               addr_q <= '0;
            end else if (load) begin
               for (int k = 0; k < NIBS; k++) begin
                  if (idx == IDX_W'(k)) addr_q[(NIBS-1-k)*4 +: 4] <= nib;
               end
            end
         end
      end
   endgenerate

   assign addr = addr_q;

endmodule

// File: rtl/lpc_rd_fsm.sv
module lpc_rd_fsm
   import lpc_rd_pkg::*;
#(
   parameter int NIBS   = 8,
   localparam int IDX_W = $clog2(NIBS)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             frm_n,
   input  logic [3:0]       nib_in,
   output lpc_st_e          st,
   output logic [IDX_W-1:0] idx,
   output logic             load
);

   localparam logic [IDX_W-1:0] LAST = IDX_W'(NIBS - 1);

   lpc_st_e st_q, st_d;

   always_comb begin
      st_d = st_q;
      unique case (st_q)
         ST_IDLE:  st_d = ST_IDLE;
         ST_CTYPE: st_d = is_mem_read(nib_in) ? ST_ADDR : ST_IDLE;
         ST_ADDR:  st_d = (idx == LAST) ? ST_HTA0 : ST_ADDR;
         ST_HTA0:  st_d = ST_HTA1;
         ST_HTA1:  st_d = ST_SYNC;
         ST_SYNC:  st_d = ST_DLO;
         ST_DLO:   st_d = ST_DHI;
         ST_DHI:   st_d = ST_REL;
         ST_REL:   st_d = ST_IDLE;
         default:  st_d = ST_IDLE;
      endcase
      // a framed nibble always overrides: start restarts, anything else idles
      if (!frm_n) st_d = (nib_in == NIB_START) ? ST_CTYPE : ST_IDLE;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q <= ST_IDLE;
         idx  <= '0;
      end else begin
         st_q <= st_d;
         idx  <= (st_q == ST_ADDR) ? idx + 1'b1 : '0;
      end
   end

   assign st   = st_q;
   assign load = (st_q == ST_ADDR) && frm_n;

endmodule

// File: rtl/lpc_rd_drive.sv
module lpc_rd_drive
   import lpc_rd_pkg::*;
(
   input  lpc_st_e    st,
   input  logic [7:0] data,
   output logic [3:0] out,
   output logic       oe
);

   always_comb begin
      oe  = 1'b1;
      out = NIB_ONES;
      unique case (st)
         ST_SYNC: out = NIB_READY;
         ST_DLO:  out = data[3:0];
         ST_DHI:  out = data[7:4];
         ST_REL:  out = NIB_ONES;
         default: oe  = 1'b0;
      endcase
   end

endmodule

// File: rtl/lpc_rd_target.sv
module lpc_rd_target
   import lpc_rd_pkg::*;
#(
   parameter int ADDR_W   = 32,
   parameter bit SHIFT_IN = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              frm_n,
   input  logic [3:0]        nib_in,
   output logic [3:0]        nib_out,
   output logic              nib_oe,
   output logic              mem_rd,
   output logic [ADDR_W-1:0] mem_addr,
   input  logic [7:0]        mem_data
);

   localparam int NIBS  = ADDR_W / 4;
   localparam int IDX_W = $clog2(NIBS);

   generate
      if ((ADDR_W % 4) != 0 || ADDR_W < 8) begin : g_bad_addr_w
         $error("ADDR_W must be a multiple of 4 and at least 8");
      end
   endgenerate

   lpc_st_e          st;
   logic [IDX_W-1:0] idx;
   logic             load;
   logic [7:0]       data_q;

   lpc_rd_fsm #(.NIBS(NIBS)) u_fsm (
      .clk    (clk),
      .rst_n  (rst_n),
      .frm_n  (frm_n),
      .nib_in (nib_in),
      .st     (st),
      .idx    (idx),
      .load   (load)
   );

   lpc_rd_addr_cap #(.ADDR_W(ADDR_W), .SHIFT_IN(SHIFT_IN)) u_addr (
      .clk   (clk),
      .rst_n (rst_n),
      .load  (load),
      .idx   (idx),
      .nib   (nib_in),
      .addr  (mem_addr)
   );

   // byte arrives the clock after the read strobe, i.e. in second turnaround
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)              data_q <= '0;
      else if (st == ST_HTA1)  data_q <= mem_data;
   end

   assign mem_rd = (st == ST_HTA0);

   lpc_rd_drive u_drv (
      .st   (st),
      .data (data_q),
      .out  (nib_out),
      .oe   (nib_oe)
   );

endmodule

// File: rtl/lpc_rd_target_chk.sv
module lpc_rd_target_chk (
   input logic       clk,
   input logic       rst_n,
   input logic       nib_oe,
   input logic [3:0] nib_out,
   input logic       mem_rd
);

   // R1: first clock out of reset the bus is not owned and no read is issued
   p_quiet_after_reset_r1: assert property (@(posedge clk)
      $rose(rst_n) |-> (!nib_oe && !mem_rd));

   // R4: the backend strobe lasts one clock
   p_rd_single_r4: assert property (@(posedge clk) disable iff (!rst_n)
      mem_rd |=> !mem_rd);

   // R5: ownership begins two clocks after the read strobe
   p_oe_after_tar_r5: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(nib_oe) |-> $past(mem_rd, 2));

   // R6: first driven nibble is the ready sync code
   p_sync_first_r6: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(nib_oe) |-> (nib_out == 4'b0000));

   // R8: the last driven nibble before release is all ones
   p_release_ones_r8: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(nib_oe) |-> ($past(nib_out) == 4'b1111));

endmodule

bind lpc_rd_target lpc_rd_target_chk u_chk (
   .clk     (clk),
   .rst_n   (rst_n),
   .nib_oe  (nib_oe),
   .nib_out (nib_out),
   .mem_rd  (mem_rd)
);

// File: tb/lpc_rd_target_bench.sv
`timescale 1ns/1ps
module lpc_rd_target_bench;

   logic        clk = 1'b0;
   logic        rst_n;
   logic        frm_n;
   logic [3:0]  nib_in;
   logic [3:0]  nib_out;
   logic        nib_oe;
   logic        mem_rd;
   logic [31:0] mem_addr;
   logic [7:0]  mem_q;

   int total = 0;
   int bad   = 0;
   int cycles = 0;

   always #10 clk = ~clk;

   lpc_rd_target u_lpc_rd_target (
      .clk      (clk),
      .rst_n    (rst_n),
      .frm_n    (frm_n),
      .nib_in   (nib_in),
      .nib_out  (nib_out),
      .nib_oe   (nib_oe),
      .mem_rd   (mem_rd),
      .mem_addr (mem_addr),
      .mem_data (mem_q)
   );

   function automatic logic [7:0] mfn(input logic [31:0] a);
      return a[7:0] ^ a[31:24] ^ 8'h5A;
   endfunction

   // backend: byte valid only in the clock right after the strobe (R7)
   always @(posedge clk) mem_q <= mem_rd ? mfn(mem_addr) : 8'h00;

   // {start nibble, cycle type, address}
   localparam int NV = 8;
   localparam logic [39:0] VEC [NV] = '{
      {4'h0, 4'h4, 32'h1234_5678},
      {4'h0, 4'h5, 32'hFFFF_FFF0},
      {4'h0, 4'h6, 32'h0000_0001},
      {4'h0, 4'h0, 32'h8000_0000},
      {4'h0, 4'hC, 32'h5555_AAAA},
      {4'h3, 4'h4, 32'h0BAD_0BAD},
      {4'h0, 4'h4, 32'hA5C3_0F1E},
      {4'h0, 4'h5, 32'h0000_0000}
   };

   task automatic chk(input string req, input string what,
                      input logic [31:0] act, input logic [31:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   task automatic tick(input logic f, input logic [3:0] l,
                       output logic oe, output logic [3:0] o,
                       output logic rd, output logic [31:0] a);
      @(negedge clk);
      oe = nib_oe; o = nib_out; rd = mem_rd; a = mem_addr;
      frm_n = f; nib_in = l;
   endtask

   task automatic run_txn(input logic [3:0] st, input logic [3:0] ct,
                          input logic [31:0] ad);
      logic ok;
      logic [7:0] d;
      logic oe, rd;
      logic [3:0] o;
      logic [31:0] a;
      string rq;
      ok = (st == 4'h0) && (ct[3:1] == 3'b010);
      d  = mfn(ad);
      rq = (st != 4'h0) ? "R2" : (ok ? "R5" : "R3");
      for (int i = 1; i <= 17; i++) begin
         logic f;
         logic [3:0] l;
         logic eoe;
         f = (i == 1) ? 1'b0 : 1'b1;
         if (i == 1)                l = st;
         else if (i == 2)           l = ct;
         else if (i >= 3 && i <= 10) l = ad[(10-i)*4 +: 4];
         else                       l = 4'hF;
         tick(f, l, oe, o, rd, a);
         eoe = ok && (i >= 13) && (i <= 16);
         chk((i == 17) ? "R8" : rq, $sformatf("oe clock %0d", i), 32'(oe), 32'(eoe));
         if (eoe) begin
            case (i)
               13: chk("R6", "sync nibble", 32'(o), 32'h0);
               14: chk("R7", "low data nibble", 32'(o), 32'(d[3:0]));
               15: chk("R7", "high data nibble", 32'(o), 32'(d[7:4]));
               default: chk("R8", "release nibble", 32'(o), 32'hF);
            endcase
         end
         chk("R4", $sformatf("mem_rd clock %0d", i), 32'(rd), 32'(ok && i == 11));
         if (ok && i == 11) chk("R4", "address", a, ad);
      end
   endtask

   initial begin : watchdog
      forever begin
         @(posedge clk);
         cycles++;
         if (cycles > 20000) begin
            bad++;
            total++;
            $display("FAIL watchdog expired");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
         end
      end
   end

   initial begin : main
      logic oe, rd;
      logic [3:0] o;
      logic [31:0] a;
      rst_n = 1'b0; frm_n = 1'b1; nib_in = 4'hF;
      repeat (3) @(negedge clk);
      chk("R1", "oe in reset", 32'(nib_oe), 32'h0);
      chk("R1", "mem_rd in reset", 32'(mem_rd), 32'h0);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R1", "oe after reset", 32'(nib_oe), 32'h0);

      for (int v = 0; v < NV; v++) run_txn(VEC[v][39:36], VEC[v][35:32], VEC[v][31:0]);

      // R9: abort after three address nibbles, then a full read
      tick(1'b0, 4'h0, oe, o, rd, a);
      tick(1'b1, 4'h4, oe, o, rd, a);
      tick(1'b1, 4'h1, oe, o, rd, a);
      tick(1'b1, 4'h2, oe, o, rd, a);
      tick(1'b1, 4'h3, oe, o, rd, a);
      chk("R9", "oe before abort", 32'(oe), 32'h0);
      run_txn(4'h0, 4'h4, 32'hCAFE_0042);

      // R1: reset while the target owns the bus
      tick(1'b0, 4'h0, oe, o, rd, a);
      tick(1'b1, 4'h4, oe, o, rd, a);
      for (int n = 0; n < 8; n++) tick(1'b1, 4'h7, oe, o, rd, a);
      for (int n = 0; n < 4; n++) tick(1'b1, 4'hF, oe, o, rd, a);
      chk("R1", "oe owned before reset", 32'(oe), 32'h1);
      rst_n = 1'b0;
      #1;
      chk("R1", "oe cleared by reset", 32'(nib_oe), 32'h0);
      repeat (2) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      run_txn(4'h0, 4'h5, 32'h7777_7777);

      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule